// File: doc/BRIEF.md
# Half-word staggered pipelined adder

The block adds two 32-bit operands in two 16-bit slices on consecutive clock cycles. The low slice is evaluated in the cycle an operation is accepted. Its sum and its carry out of bit 15 are registered. In the following cycle the high slice adds the operand high halves, which were held back one cycle, together with that registered carry. The low half of the result is therefore visible one cycle after issue, and the full result two cycles after issue.

Each operand has its own select bit. The select bit picks either the value on the input port or the result of the most recent accepted add. The low slice forwards from the producer's registered low half. The high slice forwards one cycle later from the producer's registered high half. Because of this, a chain of dependent adds can issue on every cycle without a bubble. Any number of idle cycles may separate a producer and its consumer. The forwarded value is always the result of the last valid add.

Top module: `stag_add`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first add, `lo_valid_o` and `res_valid_o` are 0, and `lo_sum_o`, `lo_carry_o`, `res_o` and `carry_o` are all 0.
- R2: One cycle after a cycle with `in_valid_i` high, `lo_valid_o` is 1. In that cycle `lo_sum_o` equals bits 15:0 of A+B and `lo_carry_o` equals the carry out of bit 15, where A and B are the effective operands.
- R3: Exactly two cycles after a cycle with `in_valid_i` high, `res_valid_o` is 1 and `res_o` equals (A+B) mod 2^32. In every other cycle `res_valid_o` is 0.
- R4: `carry_o` is the carry out of bit 31 of A+B. It is presented in the same cycle as `res_o`.
- R5: When `sel_a_i` is 1, A is the full 32-bit result of the most recent accepted add and `op_a_i` is ignored. When it is 0, A is `op_a_i`.
- R6: When `sel_b_i` is 1, B is the result of the most recent accepted add and `op_b_i` is ignored. When it is 0, B is `op_b_i`.
- R7: The forwarded value is the most recent accepted add's result even when idle cycles separate it from the consumer. Before any add after reset, the forwarded value is 0.
- R8: In a cycle that follows a cycle without `in_valid_i`, `lo_sum_o` and `lo_carry_o` keep their values. In a cycle where `res_valid_o` is 0, `res_o` and `carry_o` keep their values.
- R9: An add may be accepted on every cycle, including when each add depends on the one before it, and every result still arrives in order two cycles after its issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Accept an add this cycle |
| op_a_i | input | 32 | Operand A from the port |
| op_b_i | input | 32 | Operand B from the port |
| sel_a_i | input | 1 | 1: A is the last add's result; 0: A is op_a_i |
| sel_b_i | input | 1 | 1: B is the last add's result; 0: B is op_b_i |
| lo_valid_o | output | 1 | Low half of the result is available |
| lo_sum_o | output | 16 | Sum bits 15:0 |
| lo_carry_o | output | 1 | Carry out of bit 15 |
| res_valid_o | output | 1 | Full result is available |
| res_o | output | 32 | 32-bit sum |
| carry_o | output | 1 | Carry out of bit 31 |

## Verification
In a back-to-back dependent chain, two things happen in the same cycle. The high slice of one add completes while the low slice of the next add consumes that add's own low half. One forwarded operand slice is therefore the newly written low register and the other is the high register being written in that same cycle. The bench provokes this with chains of forwarded adds issued on every cycle. The chains use values such as 0x0000FFFF+1, where the carry across bit 15 must reach the dependent high slice. A scoreboard predicts each full result and each low half from a 32-bit reference sum. It then judges every result against its issue cycle plus one or two.

// File: rtl/stag_pkg.sv
package stag_pkg;
  typedef enum logic {
    SRC_PORT = 1'b0,
    SRC_FWD  = 1'b1
  } src_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/stag_slice_add.sv
module stag_slice_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/stag_operand_sel.sv
module stag_operand_sel #(
  parameter int unsigned W = 16
) (
  input  stag_pkg::src_e src_i,
  input  logic [W-1:0]   port_i,
  input  logic [W-1:0]   fwd_i,
  output logic [W-1:0]   opd_o
);
  always_comb begin
    unique case (src_i)
      stag_pkg::SRC_FWD: opd_o = fwd_i;
      default:           opd_o = port_i;
    endcase
  end
endmodule

// File: rtl/stag_add.sv
module stag_add #(
  parameter int unsigned SLICE_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [2*SLICE_W-1:0] op_a_i,
  input  logic [2*SLICE_W-1:0] op_b_i,
  input  logic                 sel_a_i,
  input  logic                 sel_b_i,
  output logic                 lo_valid_o,
  output logic [SLICE_W-1:0]   lo_sum_o,
  output logic                 lo_carry_o,
  output logic                 res_valid_o,
  output logic [2*SLICE_W-1:0] res_o,
  output logic                 carry_o
);
  import stag_pkg::*;

  localparam int unsigned W  = 2 * SLICE_W;
  localparam int unsigned NO = NUM_OPS;

  // operand views, index 0 = A, 1 = B
  logic [SLICE_W-1:0] port_lo [NO];
  logic [SLICE_W-1:0] port_hi [NO];
  src_e               src_in  [NO];

  assign port_lo[0] = op_a_i[SLICE_W-1:0];
  assign port_lo[1] = op_b_i[SLICE_W-1:0];
  assign port_hi[0] = op_a_i[W-1:SLICE_W];
  assign port_hi[1] = op_b_i[W-1:SLICE_W];
  assign src_in[0]  = src_e'(sel_a_i);
  assign src_in[1]  = src_e'(sel_b_i);

  // stage 1 state: low result of the most recent add
  logic               lo_v_q;
  logic [SLICE_W-1:0] lo_q;
  logic               lo_c_q;
  // high halves and sources staged for the high slice
  logic [SLICE_W-1:0] hi_opd_q [NO];
  src_e               hi_src_q [NO];

  // stage 2 state: full result of the most recent add
  logic               res_v_q;
  logic [SLICE_W-1:0] hi_q;
  logic [SLICE_W-1:0] res_lo_q;
  logic               hi_c_q;

  logic [SLICE_W-1:0] lo_opd [NO];
  logic [SLICE_W-1:0] hi_opd [NO];

  for (genvar g = 0; g < NO; g++) begin : g_opd
    stag_operand_sel #(.W(SLICE_W)) i_lo_sel (
      .src_i  (src_in[g]),
      .port_i (port_lo[g]),
      .fwd_i  (lo_q),
      .opd_o  (lo_opd[g])
    );
    stag_operand_sel #(.W(SLICE_W)) i_hi_sel (
      .src_i  (hi_src_q[g]),
      .port_i (hi_opd_q[g]),
      .fwd_i  (hi_q),
      .opd_o  (hi_opd[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_opd_q[g] <= '0;
        hi_src_q[g] <= SRC_PORT;
      end else if (in_valid_i) begin
        hi_opd_q[g] <= port_hi[g];
        hi_src_q[g] <= src_in[g];
      end
    end
  end

  logic [SLICE_W-1:0] lo_sum;
  logic               lo_cout;
  logic [SLICE_W-1:0] hi_sum;
  logic               hi_cout;

  stag_slice_add #(.W(SLICE_W)) i_lo_add (
    .a_i    (lo_opd[0]),
    .b_i    (lo_opd[1]),
    .cin_i  (1'b0),
    .sum_o  (lo_sum),
    .cout_o (lo_cout)
  );

  stag_slice_add #(.W(SLICE_W)) i_hi_add (
    .a_i    (hi_opd[0]),
    .b_i    (hi_opd[1]),
    .cin_i  (lo_c_q),
    .sum_o  (hi_sum),
    .cout_o (hi_cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_v_q <= 1'b0;
      lo_q   <= '0;
      lo_c_q <= 1'b0;
    end else begin
      lo_v_q <= in_valid_i;
      if (in_valid_i) begin
        lo_q   <= lo_sum;
        lo_c_q <= lo_cout;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_v_q  <= 1'b0;
      hi_q     <= '0;
      res_lo_q <= '0;
      hi_c_q   <= 1'b0;
    end else begin
      res_v_q <= lo_v_q;
      if (lo_v_q) begin
        hi_q     <= hi_sum;
        res_lo_q <= lo_q;
        hi_c_q   <= hi_cout;
      end
    end
  end

  assign lo_valid_o  = lo_v_q;
  assign lo_sum_o    = lo_q;
  assign lo_carry_o  = lo_c_q;
  assign res_valid_o = res_v_q;
  assign res_o       = {hi_q, res_lo_q};
  assign carry_o     = hi_c_q;
endmodule

// File: rtl/stag_add_chk.sv
module stag_add_chk #(
  parameter int unsigned SLICE_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic [2*SLICE_W-1:0] op_a_i,
  input logic [2*SLICE_W-1:0] op_b_i,
  input logic                 sel_a_i,
  input logic                 sel_b_i,
  input logic                 lo_valid_o,
  input logic [SLICE_W-1:0]   lo_sum_o,
  input logic                 lo_carry_o,
  input logic                 res_valid_o,
  input logic [2*SLICE_W-1:0] res_o,
  input logic                 carry_o
);
  p_lo_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> lo_valid_o);

  p_lo_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !lo_valid_o);

  p_lo_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !sel_a_i && !sel_b_i) |=>
      ({lo_carry_o, lo_sum_o} ==
       ({1'b0, $past(op_a_i[SLICE_W-1:0])} + {1'b0, $past(op_b_i[SLICE_W-1:0])})));

  p_res_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid_o |=> res_valid_o);

  p_res_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_valid_o |=> !res_valid_o);

  p_res_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_o[SLICE_W-1:0] == $past(lo_sum_o)));

  p_fwd_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && sel_a_i && !sel_b_i) |=>
      (lo_sum_o == $past(lo_sum_o) + $past(op_b_i[SLICE_W-1:0])));

  p_fwd_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !sel_a_i && sel_b_i) |=>
      (lo_sum_o == $past(op_a_i[SLICE_W-1:0]) + $past(lo_sum_o)));

  p_lo_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(lo_sum_o) && $stable(lo_carry_o)));

  p_res_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> ($stable(res_o) && $stable(carry_o)));
endmodule

bind stag_add stag_add_chk #(.SLICE_W(SLICE_W)) i_stag_add_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_a_i      (op_a_i),
  .op_b_i      (op_b_i),
  .sel_a_i     (sel_a_i),
  .sel_b_i     (sel_b_i),
  .lo_valid_o  (lo_valid_o),
  .lo_sum_o    (lo_sum_o),
  .lo_carry_o  (lo_carry_o),
  .res_valid_o (res_valid_o),
  .res_o       (res_o),
  .carry_o     (carry_o)
);

// File: tb/test_stag_add.sv
`timescale 1ns/1ps
module test_stag_add;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        sel_a_i = 1'b0;
  logic        sel_b_i = 1'b0;
  logic        lo_valid_o;
  logic [15:0] lo_sum_o;
  logic        lo_carry_o;
  logic        res_valid_o;
  logic [31:0] res_o;
  logic        carry_o;

  stag_add i_stag_add (
    .clk_i, .rst_ni, .in_valid_i, .op_a_i, .op_b_i, .sel_a_i, .sel_b_i,
    .lo_valid_o, .lo_sum_o, .lo_carry_o, .res_valid_o, .res_o, .carry_o
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic [31:0] sum;
    logic        cout;
    logic [15:0] lo;
    logic        lo_c;
    int          cyc;
  } item_t;

  item_t lo_q[$];
  item_t res_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] model_last = '0;
  logic [31:0] seed = 32'h1badf00d;
  logic        mon_on = 1'b0;
  logic [16:0] prev_lo = '0;
  logic [32:0] prev_res = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input bit sa, input bit sb);
    item_t it;
    logic [31:0] ea, eb;
    logic [32:0] full;
    logic [16:0] lo;
    @(negedge clk_i);
    in_valid_i = 1'b1;
    op_a_i = a; op_b_i = b; sel_a_i = sa; sel_b_i = sb;
    ea = sa ? model_last : a;
    eb = sb ? model_last : b;
    full = {1'b0, ea} + {1'b0, eb};
    lo = {1'b0, ea[15:0]} + {1'b0, eb[15:0]};
    it.sum = full[31:0]; it.cout = full[32];
    it.lo = lo[15:0]; it.lo_c = lo[16];
    it.cyc = cyc;
    lo_q.push_back(it);
    res_q.push_back(it);
    model_last = full[31:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      op_a_i = 32'hdead_beef; op_b_i = 32'h5555_aaaa;
      sel_a_i = 1'b1; sel_b_i = 1'b1;
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (lo_valid_o) begin
        if (lo_q.size() == 0) check(1'b0, "R2", "unexpected low half", {16'h0, lo_carry_o, lo_sum_o}, '0);
        else begin
          item_t e;
          e = lo_q.pop_front();
          check(cyc == e.cyc + 1, "R2", "low half timing", 33'(cyc), 33'(e.cyc + 1));
          check({lo_carry_o, lo_sum_o} == {e.lo_c, e.lo}, "R2", "low half value",
                {16'h0, lo_carry_o, lo_sum_o}, {16'h0, e.lo_c, e.lo});
        end
      end else begin
        check({lo_carry_o, lo_sum_o} == prev_lo, "R8", "low half hold",
              {16'h0, lo_carry_o, lo_sum_o}, {16'h0, prev_lo});
      end
      if (res_valid_o) begin
        if (res_q.size() == 0) check(1'b0, "R3", "unexpected result", {carry_o, res_o}, '0);
        else begin
          item_t e;
          e = res_q.pop_front();
          check(cyc == e.cyc + 2, "R9", "result timing", 33'(cyc), 33'(e.cyc + 2));
          check(res_o == e.sum, "R3", "result value", {1'b0, res_o}, {1'b0, e.sum});
          check(carry_o == e.cout, "R4", "carry out of bit 31", {32'h0, carry_o}, {32'h0, e.cout});
        end
      end else begin
        check({carry_o, res_o} == prev_res, "R8", "result hold", {carry_o, res_o}, prev_res);
      end
    end
    prev_lo  = {lo_carry_o, lo_sum_o};
    prev_res = {carry_o, res_o};
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R9 watchdog expired: actual %0d expected <100000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({lo_valid_o, res_valid_o} == 2'b00, "R1", "valids in reset", {31'h0, lo_valid_o, res_valid_o}, '0);
    check({lo_carry_o, lo_sum_o, carry_o, res_o} == '0, "R1", "data in reset",
          {carry_o, res_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({lo_valid_o, res_valid_o, lo_sum_o} == '0, "R1", "state after release",
          {15'h0, lo_valid_o, res_valid_o, lo_sum_o}, '0);
    mon_on = 1'b1;

    // R7: forwarding before any add yields 0
    issue(32'h0000_0005, 32'h0000_0007, 1'b1, 1'b0);
    idle(2);
    // R2, R3, R4: independent adds incl. carry across bit 15 and out of bit 31
    issue(32'h0000_ffff, 32'h0000_0001, 1'b0, 1'b0);
    issue(32'hffff_ffff, 32'h0000_0001, 1'b0, 1'b0);
    issue(32'h1234_5678, 32'h1111_1111, 1'b0, 1'b0);
    issue(32'h7fff_8000, 32'h0000_8000, 1'b0, 1'b0);
    issue(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    idle(3);
    // R5, R6, R9: back-to-back dependent chain with boundary carries
    issue(32'h0000_ffff, 32'h0000_0001, 1'b0, 1'b0);
    issue(32'hcafe_cafe, 32'h0000_ffff, 1'b1, 1'b0);
    issue(32'h0000_0001, 32'hbead_beef, 1'b0, 1'b1);
    issue(32'h0, 32'h0, 1'b1, 1'b1);
    issue(32'h0, 32'h0, 1'b1, 1'b1);
    issue(32'hffff_0001, 32'h0, 1'b0, 1'b1);
    idle(1);
    // R7: forward across idle cycles
    issue(32'h0001_ffff, 32'h0000_ffff, 1'b0, 1'b0);
    idle(4);
    issue(32'h1234_1234, 32'h0000_0001, 1'b1, 1'b0);
    idle(2);
    issue(32'h0, 32'h0000_8001, 1'b1, 1'b0);
    // mixed stream
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      if (seed[9]) a[15:0] = 16'hffff;
      issue(a, b, seed[3], seed[7]);
      if (seed[12:10] == 3'b000) idle(1 + int'(seed[14:13]));
    end
    idle(5);
    check(lo_q.size() == 0 && res_q.size() == 0, "R3", "results outstanding",
          33'(res_q.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule